// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block places three 8-bit parallel ports, called A, B and C, behind a small processor bus made of an 8-bit write bus, an 8-bit read bus, two address bits, a chip select, a read strobe and a write strobe. Software uses a control word to set the direction of each port. Port C is split into an upper half and a lower half, and each half has its own direction. Every port drives three vectors: the live input pins, an output latch, and an output enable. A pad ring or a board-level tri-state stage combines these vectors outside the block.

A write to the control address does one of two things, depending on its top bit. If the top bit is 1, the write is a configuration word: it sets the port directions and clears every output latch. If the top bit is 0, the write is a single-bit command: it sets or clears one bit of the port C latch and leaves the other bits as they were. Data transfers use no handshake. A write loads the latch of the addressed port. A read returns the live pins of any port or half-port set as input, and returns the latch of any port or half-port set as output.

Top module: `ppio_top`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C, and 3 selects the control register. An access counts only while cs is high.
- R2: After synchronous reset, every port is an input, every output latch holds 0x00, and every output enable is low.
- R3: A control write with wdata[7]=1 sets the directions, with 1 meaning input: wdata[4] sets port A, wdata[1] sets port B, wdata[3] sets upper port C (bits 7:4), and wdata[0] sets lower port C (bits 3:0). Bits 6:5 and 2 have no effect. Each output enable bit is 1 exactly when its bit is set as output.
- R4: A configuration write clears all three output latches. The cleared values appear on the out vectors one cycle after the write.
- R5: A control write with wdata[7]=0 writes the value wdata[0] into port C latch bit wdata[3:1]. No other bit of any latch changes, and the directions are unchanged.
- R6: A port C bit changed by a single-bit command keeps its value until another single-bit command, a port C data write, a configuration write or a reset changes it.
- R7: A data write to port A, B or C loads wdata into that port's latch, whatever the direction. The out vector shows the latch one cycle later.
- R8: A read of port A or B returns the live input pins when the port is an input, and the latch when it is an output. The result appears in the same cycle, with no sampling register in the path.
- R9: A read of the control address returns 0x00. rdata is 0x00 whenever cs and rd are not both high.
- R10: Each half of port C follows its own direction. A port C read merges the pins of an input half with the latch of an output half, and pc_oe enables each nibble on its own.
- R11: A write strobe with cs low changes no latch and no direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, acted on at the clock edge |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The internal state consists of the direction bits and the three latches, and both are visible at the ports one cycle after any write. A wrong direction bit shows up at once as a wrong oe nibble, and it also makes the next read of that port return the latch where the pins were expected, or the pins where the latch was expected. A decoding fault in a single-bit command shows on pc_out in the next cycle, either as a wrong bit or as more than one bit changing. A latch that a configuration write failed to clear shows up on the following cycle.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;
    localparam int IDX_W  = $clog2(PORT_W);
    localparam int NPORT  = 3;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // direction set: 1 = input
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_t;

    // decoded write event of one bus cycle
    typedef struct packed {
        logic [NPORT-1:0]  ld;      // data load per port (A=0,B=1,C=2)
        logic              cfg;     // configuration word
        logic              bsr;     // single bit command on port C
        logic [IDX_W-1:0]  bit_idx;
        logic              bit_val;
        logic [PORT_W-1:0] data;
    } wr_evt_t;

    localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};

    function automatic dir_t cfg_to_dir(input logic [7:0] w);
        dir_t d;
        d.a_in  = w[4];
        d.b_in  = w[1];
        d.cu_in = w[3];
        d.cl_in = w[0];
        return d;
    endfunction

    function automatic logic [PORT_W-1:0] pick(input logic use_pin,
                                               input logic [PORT_W-1:0] pin,
                                               input logic [PORT_W-1:0] lat);
        return use_pin ? pin : lat;
    endfunction

    // per-bit input mask of port C from the two half directions
    function automatic logic [PORT_W-1:0] c_in_mask(input dir_t d);
        return {{NIB_W{d.cu_in}}, {NIB_W{d.cl_in}}};
    endfunction

endpackage

// File: rtl/ppio_bus_dec.sv
module ppio_bus_dec
    import ppio_pkg::*;
(
    input  logic              cs,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output wr_evt_t           evt
);
    sel_e sel;
    logic hit;

    always_comb begin
        sel = sel_e'(addr);
        hit = cs && wr;
        evt = '0;
        evt.data    = wdata[PORT_W-1:0];
        evt.bit_idx = wdata[IDX_W:1];
        evt.bit_val = wdata[0];
        if (hit) begin
            unique case (sel)
                SEL_A:    evt.ld[0] = 1'b1;
                SEL_B:    evt.ld[1] = 1'b1;
                SEL_C:    evt.ld[2] = 1'b1;
                SEL_CTRL: begin
                    evt.cfg = wdata[7];
                    evt.bsr = !wdata[7];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
    import ppio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_we,
    input  logic [7:0] cfg_word,
    output dir_t    dir
);
    always_ff @(posedge clk) begin
        if (rst)
            dir <= DIR_RESET;
        else if (cfg_we)
            dir <= cfg_to_dir(cfg_word);
    end
endmodule

// File: rtl/ppio_out_latch.sv
module ppio_out_latch #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld,
    input  logic [W-1:0]     ld_data,
    input  logic             bit_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (ld)
            q <= ld_data;
        else if (bit_en)
            q[bit_idx] <= bit_val;
    end
endmodule

// File: rtl/ppio_rd_mux.sv
module ppio_rd_mux
    import ppio_pkg::*;
(
    input  logic              cs,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  dir_t              dir,
    input  logic [PORT_W-1:0] pa_pin,
    input  logic [PORT_W-1:0] pb_pin,
    input  logic [PORT_W-1:0] pc_pin,
    input  logic [PORT_W-1:0] pa_lat,
    input  logic [PORT_W-1:0] pb_lat,
    input  logic [PORT_W-1:0] pc_lat,
    output logic [7:0]        rdata
);
    logic [PORT_W-1:0] cmask;

    always_comb begin
        cmask = c_in_mask(dir);
        rdata = '0;
        if (cs && rd) begin
            unique case (sel_e'(addr))
                SEL_A:    rdata = pick(dir.a_in, pa_pin, pa_lat);
                SEL_B:    rdata = pick(dir.b_in, pb_pin, pb_lat);
                SEL_C:    rdata = (pc_pin & cmask) | (pc_lat & ~cmask);
                SEL_CTRL: rdata = '0;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppio_top.sv
module ppio_top
    import ppio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);
    wr_evt_t           evt;
    dir_t              dir;
    logic [PORT_W-1:0] lat [NPORT];

    ppio_bus_dec u_dec (
        .cs    (cs),
        .wr    (wr),
        .addr  (addr),
        .wdata (wdata),
        .evt   (evt)
    );

    ppio_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (evt.cfg),
        .cfg_word (wdata),
        .dir      (dir)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam bit HAS_BIT = (g == NPORT - 1);
        ppio_out_latch #(.W(PORT_W), .IDX_W(IDX_W)) u_lat (
            .clk     (clk),
            .rst     (rst),
            .clr     (evt.cfg),
            .ld      (evt.ld[g]),
            .ld_data (evt.data),
            .bit_en  (HAS_BIT ? evt.bsr : 1'b0),
            .bit_idx (evt.bit_idx),
            .bit_val (evt.bit_val),
            .q       (lat[g])
        );
    end

    ppio_rd_mux u_rd (
        .cs     (cs),
        .rd     (rd),
        .addr   (addr),
        .dir    (dir),
        .pa_pin (pa_in),
        .pb_pin (pb_in),
        .pc_pin (pc_in),
        .pa_lat (lat[0]),
        .pb_lat (lat[1]),
        .pc_lat (lat[2]),
        .rdata  (rdata)
    );

    assign pa_out = lat[0];
    assign pb_out = lat[1];
    assign pc_out = lat[2];
    assign pa_oe  = {PORT_W{!dir.a_in}};
    assign pb_oe  = {PORT_W{!dir.b_in}};
    assign pc_oe  = ~c_in_mask(dir);
endmodule

// File: rtl/ppio_chk.sv
module ppio_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       rd,
    input logic       wr,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_in,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    // R2: reset leaves latches clear and outputs disabled
    p_reset_state_r2: assert property (@(posedge clk)
        rst |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00 &&
                 pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00));

    // R4: configuration write clears every latch
    p_cfg_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == 2'd3 && wdata[7]) |=>
        (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R5: single bit command writes the selected bit and only that bit
    p_bsr_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == 2'd3 && !wdata[7]) |=>
        ($countones(pc_out ^ $past(pc_out)) <= 1 &&
         pc_out[$past(wdata[3:1])] == $past(wdata[0]) &&
         $stable(pa_out) && $stable(pb_out) && $stable(pc_oe)));

    // R11: no selected write, no latch or direction change
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !(cs && wr) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                         $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R3: enables are whole-port for A/B, whole-nibble for C
    p_oe_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) &&
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

    // R9: control address and idle bus read as zero
    p_ctrl_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!(cs && rd) || addr == 2'd3) |-> rdata == 8'h00);

    // R8: port A read source follows its direction
    p_read_a_r8: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == 2'd0) |->
        rdata == ((pa_oe[0]) ? pa_out : pa_in));
endmodule

bind ppio_top ppio_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs     (cs),
    .rd     (rd),
    .wr     (wr),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .pa_in  (pa_in),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .pc_out (pc_out),
    .pc_oe  (pc_oe)
);

// File: tb/ppio_top_tb.sv
`timescale 1ns/1ps
module ppio_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs, rd, wr;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [7:0] pc_in, pc_out, pc_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ppio_top u_dut (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // is_rd, addr, data, pins (all ports), expected, requirement number
    typedef struct packed {
        logic       is_rd;
        logic [1:0] addr;
        logic [7:0] data;
        logic [7:0] pins;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd3, 8'h80, 8'h00, 8'h00, 4'd4},  // R4 all outputs, C latch clear
        '{1'b0, 2'd0, 8'h3C, 8'h00, 8'h3C, 4'd7},  // R7 port A load
        '{1'b0, 2'd1, 8'hA5, 8'h00, 8'hA5, 4'd7},  // R7 port B load
        '{1'b1, 2'd0, 8'h00, 8'hFF, 8'h3C, 4'd8},  // R8 output port reads latch
        '{1'b0, 2'd2, 8'h0F, 8'h00, 8'h0F, 4'd7},  // R7 port C load
        '{1'b0, 2'd3, 8'h0D, 8'h00, 8'h4F, 4'd5},  // R5 set bit 6
        '{1'b0, 2'd3, 8'h00, 8'h00, 8'h4E, 4'd5},  // R5 clear bit 0
        '{1'b0, 2'd3, 8'h0F, 8'h00, 8'hCE, 4'd5},  // R5 set bit 7
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'hCE, 4'd6},  // R6 bits held
        '{1'b0, 2'd3, 8'h9B, 8'h00, 8'h00, 4'd4},  // R4 all inputs, latch clear
        '{1'b1, 2'd0, 8'h00, 8'h5A, 8'h5A, 4'd8},  // R8 input A reads pins
        '{1'b1, 2'd1, 8'h00, 8'h77, 8'h77, 4'd8},  // R8 input B reads pins
        '{1'b1, 2'd3, 8'h00, 8'hFF, 8'h00, 4'd9},  // R9 control reads zero
        '{1'b0, 2'd3, 8'h88, 8'h00, 8'h00, 4'd3},  // R3 upper C input only
        '{1'b0, 2'd2, 8'hFF, 8'h00, 8'hFF, 4'd7},  // R7 C load
        '{1'b1, 2'd2, 8'h00, 8'h30, 8'h3F, 4'd10}, // R10 upper pins, lower latch
        '{1'b0, 2'd3, 8'h81, 8'h00, 8'h00, 4'd3},  // R3 lower C input only
        '{1'b0, 2'd2, 8'hA0, 8'h00, 8'hA0, 4'd7},  // R7 C load
        '{1'b1, 2'd2, 8'h00, 8'h0C, 8'hAC, 4'd10}, // R10 upper latch, lower pins
        '{1'b0, 2'd3, 8'hE4, 8'h00, 8'h00, 4'd3},  // R3 mode bits ignored
        '{1'b1, 2'd0, 8'h00, 8'hFF, 8'h00, 4'd3}   // R3 A stays output
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic [7:0] p);
        pa_in = p; pb_in = p; pc_in = p;
    endtask

    task automatic bus_write(input logic sel, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = sel; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    function automatic logic [7:0] out_of(input logic [1:0] a);
        case (a)
            2'd0:    return pa_out;
            2'd1:    return pb_out;
            default: return pc_out;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'h00;
        set_pins(8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2 reset state
        check("R2 pa_out", pa_out, 8'h00);
        check("R2 pc_out", pc_out, 8'h00);
        check("R2 oe", pa_oe | pb_oe | pc_oe, 8'h00);
        set_pins(8'h96);
        bus_read(2'd0, r);
        check("R2 A is input", r, 8'h96);

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_pins(VEC[i].pins);
            if (VEC[i].is_rd) begin
                bus_read(VEC[i].addr, r);
            end else begin
                bus_write(1'b1, VEC[i].addr, VEC[i].data);
                r = out_of(VEC[i].addr);
            end
            n_run++;
            if (r !== VEC[i].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%02h expected=%02h",
                         VEC[i].req, i, r, VEC[i].exp);
            end
        end

        // R3 enables per direction
        bus_write(1'b1, 2'd3, 8'h80);
        check("R3 pa_oe out", pa_oe, 8'hFF);
        check("R3 pc_oe out", pc_oe, 8'hFF);
        bus_write(1'b1, 2'd3, 8'h88);
        check("R3 R10 pc_oe upper in", pc_oe, 8'h0F);
        check("R3 pb_oe", pb_oe, 8'hFF);
        bus_write(1'b1, 2'd3, 8'h9B);
        check("R3 all in", pa_oe | pb_oe | pc_oe, 8'h00);

        // R1 address map: distinct ports, written by address
        bus_write(1'b1, 2'd3, 8'h80);
        bus_write(1'b1, 2'd0, 8'h11);
        bus_write(1'b1, 2'd1, 8'h22);
        bus_write(1'b1, 2'd2, 8'h33);
        check("R1 A", pa_out, 8'h11);
        check("R1 B", pb_out, 8'h22);
        check("R1 C", pc_out, 8'h33);

        // R11 write without chip select
        bus_write(1'b0, 2'd0, 8'hEE);
        bus_write(1'b0, 2'd3, 8'h9B);
        check("R11 A unchanged", pa_out, 8'h11);
        check("R11 dir unchanged", pa_oe, 8'hFF);

        // R9 idle read bus
        @(negedge clk); cs = 1'b1; rd = 1'b0; addr = 2'd0;
        #1 check("R9 idle rdata", rdata, 8'h00);
        @(negedge clk); cs = 1'b0;

        // R6 bit survives unrelated writes, then data write overrides it
        bus_write(1'b1, 2'd3, 8'h05);     // set bit 2
        check("R5 set bit2", pc_out, 8'h37);
        bus_write(1'b1, 2'd0, 8'h44);
        bus_write(1'b1, 2'd1, 8'h55);
        check("R6 bit2 held", pc_out, 8'h37);
        bus_write(1'b1, 2'd2, 8'h00);
        check("R6 data write overrides", pc_out, 8'h00);

        // R2 reset mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R2 rerun latch", pa_out | pb_out | pc_out, 8'h00);
        check("R2 rerun oe", pa_oe | pb_oe | pc_oe, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule